// File: doc/BRIEF.md
# Converter Output Power Sequencer

This block decides when the analog output path of a stereo audio converter may be powered, and in which order, so that the line outputs never jump. It runs on a free-running system clock. It watches two incoming clocks: the converter's master clock and its left/right frame clock. From reset it holds everything off. Once both clocks are alive, it checks that one frame holds a legal number of master-clock cycles. It then brings up the voltage reference, then the converter core and filters, with the outputs still tied to ground. Next it raises a ramp code linearly toward the quiescent level, and only then lets audio through.

Every phase of the power-up is timed in frames, that is, rising edges of the frame clock. If either clock disappears at any point after power-down has been left, the block mutes at once, disconnects the output drivers and switches in a soft discharge sink for a fixed number of system clocks. A new power-up cannot start before that interval ends. The outputs are plain enables plus a ramp code. A 3-bit phase code exposes the sequence.

Top module: `dac_power_seq`

## Requirements
- R1: While reset is applied and right after it, the phase code is 0 (off). Only `clampEn` is high, `coreRstN` is low, and `rampCode` is 0.
- R2: The block leaves the off phase for the measure phase only when both clocks are present. The master clock counts as present if it had a rising edge within the last `MCLK_LOSS` system clocks. The frame clock counts as present if it had a rising edge within the last `LRCK_LOSS` master-clock rising edges.
- R3: In the measure phase (code 1), the first frame edge is ignored. At each later frame edge, the number of master-clock rising edges in the frame just ended is tested. It is legal when it lies in [`MIN_RATIO`, `MAX_RATIO`] and is a multiple of 2^`GRAIN_LOG2`. An illegal count keeps the block measuring. A legal count moves it to the reference phase (code 2).
- R4: The reference phase enables only `refEn` (with `clampEn`) for `REF_FRAMES` frame edges. The clamp phase (code 3) then adds `dacEn` and releases `coreRstN`, with the outputs still clamped, for `CLAMP_FRAMES` frame edges. `dacEn` never rises unless `refEn` was already high.
- R5: In the ramp phase (code 4), `driveEn` replaces `clampEn`. After k frame edges in this phase, `rampCode` equals floor(k·(2^`CODE_W`−1)/`RAMP_FRAMES`). The code never falls while the ramp runs. The phase lasts `RAMP_FRAMES` frame edges.
- R6: The run phase (code 5) is entered only from the ramp phase. It raises `audioEn` and holds `rampCode` at 2^`CODE_W`−1.
- R7: If either clock is absent in phases 1 to 5, the next cycle is the discharge phase (code 6). In that phase only `sinkEn` is high, `coreRstN` is low, and `rampCode` is 0.
- R8: The discharge phase lasts exactly `DRAIN_CYCLES` system clocks, even if both clocks return during it, and then goes to the off phase.
- R9: The phase code takes only the values 0 to 6 listed above.
- R10: At every cycle exactly one of `clampEn`, `driveEn` and `sinkEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running system clock |
| rstN | input | 1 | asynchronous active-low reset |
| mclkIn | input | 1 | converter master clock, sampled by `clk` |
| lrckIn | input | 1 | frame (left/right) clock, sampled by `clk` |
| refEn | output | 1 | voltage reference enable |
| dacEn | output | 1 | converter and filter power enable |
| coreRstN | output | 1 | active-low reset of interpolator and modulator |
| clampEn | output | 1 | tie outputs to ground |
| driveEn | output | 1 | connect output drivers |
| sinkEn | output | 1 | soft discharge sink enable |
| audioEn | output | 1 | unmute audio |
| rampCode | output | CODE_W | output level ramp code |
| seqState | output | 3 | current phase code |

## Verification
The ratio check is driven with frame lengths below the minimum, above the maximum and off the grain, which must all hold the block in the measure phase. Legal lengths at both range limits and random legal values in between must each complete the sequence with the same frame-counted phase lengths. This separates a frame-based timer from one based on cycles. Clock loss is injected in turn on the master clock and on the frame clock, at random points in the clamp, ramp and run phases. Restoring the clocks early inside the discharge phase shows whether the discharge interval is really fixed. The ramp code is sampled in the middle of each frame, so an off-by-one frame count shows up as a wrong code.

// File: rtl/dac_power_seq_pkg.sv
`timescale 1ns/1ps
package dac_power_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_MEASURE = 3'd1,
    ST_REF     = 3'd2,
    ST_CLAMP   = 3'd3,
    ST_RAMP    = 3'd4,
    ST_RUN     = 3'd5,
    ST_DRAIN   = 3'd6
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPhase;    // restart frame counter of the current phase
    logic clrMeasure;  // forget any frame seen so far
    logic loadDrain;   // start discharge interval
    logic rampActive;  // ramp code follows the phase counter
    logic rampFull;    // ramp code at full level
  } seqCmd_t;

  function automatic int phaseWidth(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/dac_power_seq_dp.sv
`timescale 1ns/1ps
module dac_power_seq_dp
  import dac_power_seq_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int MIN_RATIO    = 128,
  parameter int MAX_RATIO    = 512,
  parameter int GRAIN_LOG2   = 6,
  parameter int MCLK_LOSS    = 64,
  parameter int LRCK_LOSS    = 1100,
  parameter int REF_FRAMES   = 16,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DRAIN_CYCLES = 20000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkIn,
  input  logic              lrckIn,
  input  seqCmd_t           cmd,
  output logic              mclkOk,
  output logic              lrckOk,
  output logic              frameTick,
  output logic              ratioGood,
  output logic              drainDone,
  output logic [phaseWidth(REF_FRAMES, CLAMP_FRAMES, RAMP_FRAMES)-1:0] phaseCnt,
  output logic [CODE_W-1:0] rampCode
);

  localparam int PHASE_W = phaseWidth(REF_FRAMES, CLAMP_FRAMES, RAMP_FRAMES);
  localparam int MAGE_W  = $clog2(MCLK_LOSS + 1);
  localparam int LAGE_W  = $clog2(LRCK_LOSS + 1);
  localparam int RCNT_W  = $clog2(MAX_RATIO + 2);
  localparam int DRAIN_W = $clog2(DRAIN_CYCLES + 1);
  localparam int PROD_W  = PHASE_W + CODE_W;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  localparam logic [MAGE_W-1:0]  MAGE_LIM = MAGE_W'(MCLK_LOSS);
  localparam logic [LAGE_W-1:0]  LAGE_LIM = LAGE_W'(LRCK_LOSS);
  localparam logic [RCNT_W-1:0]  RCNT_SAT = RCNT_W'(MAX_RATIO + 1);
  localparam logic [RCNT_W-1:0]  RCNT_MIN = RCNT_W'(MIN_RATIO);
  localparam logic [RCNT_W-1:0]  RCNT_MAX = RCNT_W'(MAX_RATIO);
  localparam logic [PHASE_W-1:0] PHASE_SAT = '1;

  logic mclkS, mclkP, lrckS, lrckP;
  logic mclkRise, lrckRise;
  logic [MAGE_W-1:0]  mclkAge;
  logic [LAGE_W-1:0]  lrckAge;
  logic [RCNT_W-1:0]  ratioCnt;
  logic               frameSeen;
  logic               grainOk;
  logic [DRAIN_W-1:0] drainCnt;
  logic [PROD_W-1:0]  rampProd;
  logic [PROD_W-1:0]  rampStep;

  // edge detection on the sampled clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkS <= 1'b0; mclkP <= 1'b0;
      lrckS <= 1'b0; lrckP <= 1'b0;
    end else begin
      mclkS <= mclkIn; mclkP <= mclkS;
      lrckS <= lrckIn; lrckP <= lrckS;
    end
  end

  assign mclkRise  = mclkS & ~mclkP;
  assign lrckRise  = lrckS & ~lrckP;
  assign frameTick = lrckRise;

  // presence: age since last edge, absent once the limit is reached
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkAge <= MAGE_LIM;
      lrckAge <= LAGE_LIM;
    end else begin
      if (mclkRise)                mclkAge <= '0;
      else if (mclkAge != MAGE_LIM) mclkAge <= mclkAge + 1'b1;
      if (lrckRise)                            lrckAge <= '0;
      else if (mclkRise && lrckAge != LAGE_LIM) lrckAge <= lrckAge + 1'b1;
    end
  end

  assign mclkOk = (mclkAge < MAGE_LIM);
  assign lrckOk = (lrckAge < LAGE_LIM);

  // master clocks per frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioCnt  <= '0;
      frameSeen <= 1'b0;
    end else begin
      if (lrckRise)                          ratioCnt <= mclkRise ? RCNT_W'(1) : '0;
      else if (mclkRise && ratioCnt != RCNT_SAT) ratioCnt <= ratioCnt + 1'b1;
      if (cmd.clrMeasure)  frameSeen <= 1'b0;
      else if (lrckRise)   frameSeen <= 1'b1;
    end
  end

  generate
    if (GRAIN_LOG2 > 0) begin : g_grain
      assign grainOk = (ratioCnt[GRAIN_LOG2-1:0] == '0);
    end else begin : g_nograin
      assign grainOk = 1'b1;
    end
  endgenerate

  assign ratioGood = lrckRise && frameSeen && grainOk &&
                     (ratioCnt >= RCNT_MIN) && (ratioCnt <= RCNT_MAX);

  // frames spent in the current phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            phaseCnt <= '0;
    else if (cmd.clrPhase)                phaseCnt <= '0;
    else if (lrckRise && phaseCnt != PHASE_SAT) phaseCnt <= phaseCnt + 1'b1;
  end

  // discharge interval in system clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               drainCnt <= '0;
    else if (cmd.loadDrain)  drainCnt <= DRAIN_W'(DRAIN_CYCLES - 1);
    else if (drainCnt != '0) drainCnt <= drainCnt - 1'b1;
  end

  assign drainDone = (drainCnt == '0);

  // linear ramp code
  always_comb begin
    rampProd = PROD_W'(phaseCnt) * PROD_W'(CODE_MAX);
    rampStep = rampProd / PROD_W'(RAMP_FRAMES);
    if (cmd.rampFull)        rampCode = CODE_W'(CODE_MAX);
    else if (cmd.rampActive) rampCode = CODE_W'(rampStep);
    else                     rampCode = '0;
  end

  assert_ramp_monotone_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rampActive && $past(cmd.rampActive)) |-> (rampCode >= $past(rampCode)));

  assert_drain_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadDrain |=> !drainDone || (DRAIN_CYCLES == 1));

endmodule

// File: rtl/dac_power_seq_ctl.sv
`timescale 1ns/1ps
module dac_power_seq_ctl
  import dac_power_seq_pkg::*;
#(
  parameter int REF_FRAMES   = 16,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      mclkOk,
  input  logic      lrckOk,
  input  logic      frameTick,
  input  logic      ratioGood,
  input  logic      drainDone,
  input  logic [phaseWidth(REF_FRAMES, CLAMP_FRAMES, RAMP_FRAMES)-1:0] phaseCnt,
  output seqCmd_t   cmd,
  output logic      refEn,
  output logic      dacEn,
  output logic      coreRstN,
  output logic      clampEn,
  output logic      driveEn,
  output logic      sinkEn,
  output logic      audioEn,
  output logic [2:0] seqState
);

  localparam int PHASE_W = phaseWidth(REF_FRAMES, CLAMP_FRAMES, RAMP_FRAMES);
  localparam logic [PHASE_W-1:0] REF_LAST   = PHASE_W'(REF_FRAMES - 1);
  localparam logic [PHASE_W-1:0] CLAMP_LAST = PHASE_W'(CLAMP_FRAMES - 1);
  localparam logic [PHASE_W-1:0] RAMP_LAST  = PHASE_W'(RAMP_FRAMES - 1);

  seqState_e state, nextState;
  logic clocksOk;

  assign clocksOk = mclkOk && lrckOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    cmd.rampActive = (state == ST_RAMP);
    cmd.rampFull   = (state == ST_RUN);
    unique case (state)
      ST_OFF: begin
        cmd.clrMeasure = 1'b1;
        cmd.clrPhase   = 1'b1;
        if (clocksOk) nextState = ST_MEASURE;
      end
      ST_MEASURE: begin
        if (!clocksOk) begin
          nextState = ST_DRAIN; cmd.loadDrain = 1'b1;
        end else if (ratioGood) begin
          nextState = ST_REF; cmd.clrPhase = 1'b1;
        end
      end
      ST_REF: begin
        if (!clocksOk) begin
          nextState = ST_DRAIN; cmd.loadDrain = 1'b1;
        end else if (frameTick && phaseCnt == REF_LAST) begin
          nextState = ST_CLAMP; cmd.clrPhase = 1'b1;
        end
      end
      ST_CLAMP: begin
        if (!clocksOk) begin
          nextState = ST_DRAIN; cmd.loadDrain = 1'b1;
        end else if (frameTick && phaseCnt == CLAMP_LAST) begin
          nextState = ST_RAMP; cmd.clrPhase = 1'b1;
        end
      end
      ST_RAMP: begin
        if (!clocksOk) begin
          nextState = ST_DRAIN; cmd.loadDrain = 1'b1;
        end else if (frameTick && phaseCnt == RAMP_LAST) begin
          nextState = ST_RUN; cmd.clrPhase = 1'b1;
        end
      end
      ST_RUN: begin
        if (!clocksOk) begin
          nextState = ST_DRAIN; cmd.loadDrain = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (drainDone) nextState = ST_OFF;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_comb begin
    refEn    = state inside {ST_REF, ST_CLAMP, ST_RAMP, ST_RUN};
    dacEn    = state inside {ST_CLAMP, ST_RAMP, ST_RUN};
    coreRstN = dacEn;
    clampEn  = state inside {ST_OFF, ST_MEASURE, ST_REF, ST_CLAMP};
    driveEn  = state inside {ST_RAMP, ST_RUN};
    sinkEn   = (state == ST_DRAIN);
    audioEn  = (state == ST_RUN);
  end

  assign seqState = state;

  assert_off_waits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !clocksOk) |=> state == ST_OFF);

  assert_measure_needs_ratio_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MEASURE && clocksOk && !ratioGood) |=> state == ST_MEASURE);

  assert_ref_before_dac_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacEn) |-> $past(refEn));

  assert_run_from_ramp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(audioEn) |-> $past(state) == ST_RAMP);

  assert_loss_drains_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((state inside {ST_MEASURE, ST_REF, ST_CLAMP, ST_RAMP, ST_RUN}) && !clocksOk)
    |=> state == ST_DRAIN);

  assert_drain_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !drainDone) |=> state == ST_DRAIN);

  assert_state_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqState != 3'd7);

  assert_one_path_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({clampEn, driveEn, sinkEn}) == 1);

endmodule

// File: rtl/dac_power_seq.sv
`timescale 1ns/1ps
module dac_power_seq
  import dac_power_seq_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int MIN_RATIO    = 128,
  parameter int MAX_RATIO    = 512,
  parameter int GRAIN_LOG2   = 6,
  parameter int MCLK_LOSS    = 64,
  parameter int LRCK_LOSS    = 1100,
  parameter int REF_FRAMES   = 16,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DRAIN_CYCLES = 20000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkIn,
  input  logic              lrckIn,
  output logic              refEn,
  output logic              dacEn,
  output logic              coreRstN,
  output logic              clampEn,
  output logic              driveEn,
  output logic              sinkEn,
  output logic              audioEn,
  output logic [CODE_W-1:0] rampCode,
  output logic [2:0]        seqState
);

  localparam int PHASE_W = phaseWidth(REF_FRAMES, CLAMP_FRAMES, RAMP_FRAMES);

  seqCmd_t cmd;
  logic mclkOk, lrckOk, frameTick, ratioGood, drainDone;
  logic [PHASE_W-1:0] phaseCnt;

  dac_power_seq_dp #(
    .CODE_W(CODE_W), .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO),
    .GRAIN_LOG2(GRAIN_LOG2), .MCLK_LOSS(MCLK_LOSS), .LRCK_LOSS(LRCK_LOSS),
    .REF_FRAMES(REF_FRAMES), .CLAMP_FRAMES(CLAMP_FRAMES),
    .RAMP_FRAMES(RAMP_FRAMES), .DRAIN_CYCLES(DRAIN_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn), .cmd(cmd),
    .mclkOk(mclkOk), .lrckOk(lrckOk), .frameTick(frameTick),
    .ratioGood(ratioGood), .drainDone(drainDone), .phaseCnt(phaseCnt),
    .rampCode(rampCode)
  );

  dac_power_seq_ctl #(
    .REF_FRAMES(REF_FRAMES), .CLAMP_FRAMES(CLAMP_FRAMES), .RAMP_FRAMES(RAMP_FRAMES)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .mclkOk(mclkOk), .lrckOk(lrckOk),
    .frameTick(frameTick), .ratioGood(ratioGood), .drainDone(drainDone),
    .phaseCnt(phaseCnt), .cmd(cmd), .refEn(refEn), .dacEn(dacEn),
    .coreRstN(coreRstN), .clampEn(clampEn), .driveEn(driveEn),
    .sinkEn(sinkEn), .audioEn(audioEn), .seqState(seqState)
  );

endmodule

// File: tb/test_dac_power_seq.sv
`timescale 1ns/1ps
module test_dac_power_seq;

  localparam int CW = 8, MINR = 8, MAXR = 32, GL = 2, ML = 16, LL = 48;
  localparam int RF = 2, CF = 4, PF = 8, DC = 100;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclk = 1'b0, lrck = 1'b0;
  logic refEn, dacEn, coreRstN, clampEn, driveEn, sinkEn, audioEn;
  logic [CW-1:0] rampCode;
  logic [2:0] seqState;

  int checks = 0, fails = 0;
  bit mclkRun = 0, lrckRun = 0;
  int ratio = 16;
  int phase = 0, lhalf = 0, riseCount = 0, sinceRise = 0;
  int prevSt = 0, cyclesIn = 0, entryRise = 0;
  int durCycles [8];
  int durFrames [8];
  int pred [8];

  dac_power_seq #(
    .CODE_W(CW), .MIN_RATIO(MINR), .MAX_RATIO(MAXR), .GRAIN_LOG2(GL),
    .MCLK_LOSS(ML), .LRCK_LOSS(LL), .REF_FRAMES(RF), .CLAMP_FRAMES(CF),
    .RAMP_FRAMES(PF), .DRAIN_CYCLES(DC)
  ) i_dac_power_seq (
    .clk(clk), .rstN(rstN), .mclkIn(mclk), .lrckIn(lrck),
    .refEn(refEn), .dacEn(dacEn), .coreRstN(coreRstN), .clampEn(clampEn),
    .driveEn(driveEn), .sinkEn(sinkEn), .audioEn(audioEn),
    .rampCode(rampCode), .seqState(seqState)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {refEn,dacEn,coreRstN,clampEn,driveEn,sinkEn,audioEn} per phase
  function automatic logic [6:0] expOut(input int st);
    case (st)
      0, 1:    return 7'b0001000;
      2:       return 7'b1001000;
      3:       return 7'b1111000;
      4:       return 7'b1110100;
      5:       return 7'b1110101;
      default: return 7'b0000010;
    endcase
  endfunction

  function automatic string tagOf(input int st);
    case (st)
      0: return "R1";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic checkPhase(input int st);
    logic [6:0] got;
    got = {refEn, dacEn, coreRstN, clampEn, driveEn, sinkEn, audioEn};
    check(st <= 6, "R9", st, 6);
    check(got == expOut(st), tagOf(st), got, expOut(st));
    check(int'(rampCode) == ((st == 5) ? CMAX : 0), tagOf(st), rampCode, (st == 5) ? CMAX : 0);
    check($countones({clampEn, driveEn, sinkEn}) == 1, "R10",
          $countones({clampEn, driveEn, sinkEn}), 1);
  endtask

  // clock driver and monitor
  always @(negedge clk) begin
    sinceRise++;
    if (mclkRun) begin
      phase++;
      if (phase == 2) begin
        phase = 0;
        mclk = ~mclk;
        if (!mclk && lrckRun) begin
          lhalf++;
          if (lhalf >= ratio / 2) begin
            lhalf = 0;
            lrck = ~lrck;
            if (lrck) begin riseCount++; sinceRise = 0; end
          end
        end
      end
    end
    if (rstN) begin
      int st;
      st = int'(seqState);
      if (st != prevSt) begin
        durCycles[prevSt] = cyclesIn;
        durFrames[prevSt] = riseCount - entryRise;
        pred[st] = prevSt;
        prevSt = st;
        cyclesIn = 1;
        entryRise = riseCount;
        checkPhase(st);
      end else begin
        cyclesIn++;
      end
      if (st == 4 && sinceRise == 20)
        check(int'(rampCode) == (riseCount - entryRise) * CMAX / PF, "R5",
              rampCode, (riseCount - entryRise) * CMAX / PF);
    end
  end

  task automatic waitState(input int s, input int maxCyc, input string req);
    int n;
    n = 0;
    while (int'(seqState) != s && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
    check(int'(seqState) == s, req, seqState, s);
  endtask

  task automatic waitFrames(input int n);
    repeat (n * ratio * 4) @(negedge clk);
  endtask

  task automatic checkPowerUp();
    check(durFrames[2] == RF, "R4", durFrames[2], RF);
    check(durFrames[3] == CF, "R4", durFrames[3], CF);
    check(durFrames[4] == PF, "R5", durFrames[4], PF);
    check(pred[5] == 4, "R6", pred[5], 4);
    check(pred[2] == 1, "R3", pred[2], 1);
    check(pred[1] == 0, "R2", pred[1], 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(seqState == 3'd0, "R1", seqState, 0);
    checkPhase(0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkPhase(0);

    // no clocks, then master clock alone
    repeat (200) @(negedge clk);
    check(seqState == 3'd0, "R2", seqState, 0);
    mclkRun = 1;
    repeat (300) @(negedge clk);
    check(seqState == 3'd0, "R2", seqState, 0);

    // illegal frame lengths: off grain, too long, too short
    ratio = 10; lrckRun = 1;
    waitState(1, 300, "R2");
    waitFrames(6);
    check(seqState == 3'd1, "R3", seqState, 1);
    ratio = 40;
    waitFrames(5);
    check(seqState == 3'd1, "R3", seqState, 1);
    ratio = 6;
    waitFrames(6);
    check(seqState == 3'd1, "R3", seqState, 1);

    // legal ratio, full power-up
    ratio = 16;
    waitState(5, 4000, "R6");
    repeat (2) @(negedge clk);
    checkPowerUp();

    // master clock lost while running
    mclkRun = 0;
    waitState(6, ML + 10, "R7");
    waitState(0, DC + 20, "R8");
    repeat (2) @(negedge clk);
    check(durCycles[6] == DC, "R8", durCycles[6], DC);

    // frame clock lost during ramp, returns early in discharge
    mclkRun = 1;
    waitState(4, 4000, "R5");
    lrckRun = 0;
    waitState(6, LL * 4 + 40, "R7");
    repeat (5) @(negedge clk);
    lrckRun = 1;
    waitState(0, DC + 20, "R8");
    repeat (2) @(negedge clk);
    check(durCycles[6] == DC, "R8", durCycles[6], DC);

    // random ratios and loss points
    for (int it = 0; it < 6; it++) begin
      int ls;
      ratio = (it == 0) ? MINR : (it == 1) ? MAXR : (MINR + 4 * int'($urandom % 7));
      ls = 3 + int'($urandom % 3);
      waitState(ls, 40 * ratio * 4, "R4");
      if ($urandom % 2) mclkRun = 0;
      else              lrckRun = 0;
      waitState(6, LL * 4 + 40, "R7");
      repeat (3) @(negedge clk);
      mclkRun = 1; lrckRun = 1;
      waitState(0, DC + 20, "R8");
      repeat (2) @(negedge clk);
      check(durCycles[6] == DC, "R8", durCycles[6], DC);
      check(durFrames[2] == RF, "R4", durFrames[2], RF);
      if (ls >= 4) check(durFrames[3] == CF, "R4", durFrames[3], CF);
      if (ls == 5) check(durFrames[4] == PF, "R5", durFrames[4], PF);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule